// File: doc/BRIEF.md
# Warp Engine Command Decoder

This block sits in front of a geometric-distortion-correction engine and turns a stream of 32-bit command tokens into the engine's configuration. Tokens arrive on a valid/ready handshake. A token with its top bit set is a configure token: it names one of the register slots and writes a value into it. A token with its top bit clear is a data token. Data tokens are not addressed. Their meaning comes from their position in a sequence whose length and layout depend on the processing mode: three tokens when scaling, ten when warping to a four-corner tetragon.

When the final token of a sequence is accepted, the block raises a one-cycle job-start pulse. At the same moment it freezes a snapshot of everything the engine needs: mode, source and destination addresses, the unpacked scale fractions, the corner coordinates, and the interpolation, scan and throughput selections. It then stays busy and refuses further tokens until the engine reports completion. Any slot can be read back through a registered read port. Slot 0 reports the sequencer's progress.

Top module: `warp_cmd_decoder`

## Requirements
- R1: `tok_ready` is high exactly when `busy` is low. While `busy` is high no token is taken, so a configure token offered then leaves its target slot unchanged.
- R2: A configure token (bit 31 = 1) with slot number bits 29..25 in 1..26 stores bits 24..0, zero-extended to 26 bits. Setting `rd_idx` to that slot makes `rd_data` show the value zero-extended to 32 bits after one clock edge.
- R3: Configure tokens naming slot 0 or slots 27..31 change nothing. Reading slots 27..31 returns zero.
- R4: When slot 26 bit 0 is 0 (the value after reset), a sequence is three data tokens, stored in order into slot 4 (packed scale word), slot 7 (source) and slot 11 (destination).
- R5: When slot 26 bit 0 is 1, a sequence is ten data tokens, stored into slots 15 through 22 (corner 0 x, corner 0 y, up to corner 3 y), then slot 7, then slot 11.
- R6: A data token carries a 26-bit payload in bits 25..0. In the snapshot the packed scale word is split as `job_frac_x` = bits 9..0, `job_int_x` = bits 15..10 and `job_frac_y` = bits 25..16.
- R7: `job_start` is high for exactly the one cycle after the final data token is accepted. `busy` rises in that same cycle.
- R8: `busy` stays high until `job_done` is sampled high. `busy` is low and `tok_ready` is high in the cycle after that.
- R9: A configure token accepted in the middle of a sequence is stored and does not restart the token count. A write to slot 26 affects only sequences that begin after it.
- R10: Reading slot 0 returns the sequencer state in bits 1..0 (0 idle, 1 collecting, 2 busy), the number of data tokens taken so far in the current sequence in bits 15..2, and zeros elsewhere.
- R11: The snapshot, valid from the `job_start` cycle until the next job, holds the following:
  - `job_tetragon`: the mode the sequence ran in.
  - `job_src`: slot 7.
  - `job_dst`: the final token's payload.
  - `job_run_flag`: bit 30 of the final token.
  - `job_corners`: slots 15..22, with slot 15+k at bits [26k+25:26k].
  - `job_interp`: slot 24 bits 1..0 (0 nearest, 1 bilinear, 2 bicubic, 3 table).
  - `job_scan`: slot 25 bit 0 (0 down first, 1 right first).
  - `job_perf`: slot 23 bits 1..0 (0 one pixel, 1 two wide, 2 two tall, 3 two by two per cycle).
- R12: After reset, `tok_ready` is 1, and `busy`, `job_start` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token can be taken |
| tok_data | input | 32 | Command token |
| job_done | input | 1 | Engine finished the current job |
| rd_idx | input | 5 | Slot to read back |
| rd_data | output | 32 | Read-back value, one cycle after `rd_idx` |
| busy | output | 1 | Job running, tokens refused |
| job_start | output | 1 | One-cycle job launch pulse |
| job_tetragon | output | 1 | Snapshot: 1 tetragon, 0 scaling |
| job_run_flag | output | 1 | Snapshot: run-type flag of the final token |
| job_src | output | 26 | Snapshot: source address |
| job_dst | output | 26 | Snapshot: destination address |
| job_frac_x | output | 10 | Snapshot: horizontal fraction |
| job_int_x | output | 6 | Snapshot: horizontal integer step |
| job_frac_y | output | 10 | Snapshot: vertical fraction |
| job_corners | output | 208 | Snapshot: eight corner coordinates |
| job_interp | output | 2 | Snapshot: interpolation kind |
| job_scan | output | 1 | Snapshot: scan direction |
| job_perf | output | 2 | Snapshot: pixels per cycle |

## Verification
A token counts as taken on the rising edge where it is offered while ready. Slot contents, `busy` and the snapshot change on that same edge, and `job_start` is high for the next cycle only. Read-back costs one edge from `rd_idx` to `rd_data`. `busy` drops on the edge that samples `job_done`. The bench drives inputs on falling edges and samples on the falling edge that follows the edge where a result is due. It therefore checks `job_start`, `busy` and the snapshot right after the final token, and checks that `job_start` is gone one cycle later.

// File: rtl/warp_cmd_pkg.sv
package warp_cmd_pkg;
  // token bit positions (decoded by the producer, so fixed)
  localparam int TOK_W     = 32;
  localparam int CMD_BIT   = 31;
  localparam int RUN_BIT   = 30;
  localparam int ID_LSB    = 25;
  localparam int ID_W      = 5;
  localparam int CFG_VAL_W = 25;
  localparam int DAT_VAL_W = 26;

  localparam int NUM_SLOTS = 27;
  localparam int POS_W     = 4;
  localparam int SCALE_LEN = 3;
  localparam int TETRA_LEN = 10;
  localparam int CORNERS   = 8;

  // slot numbers the sequencer and snapshot depend on
  localparam int SLOT_STATUS  = 0;
  localparam int SLOT_PACKED  = 4;
  localparam int SLOT_SRC     = 7;
  localparam int SLOT_DST     = 11;
  localparam int SLOT_CORNER0 = 15;
  localparam int SLOT_PERF    = 23;
  localparam int SLOT_INTERP  = 24;
  localparam int SLOT_SCAN    = 25;
  localparam int SLOT_MODE    = 26;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_COLLECT = 2'd1,
    SEQ_BUSY    = 2'd2
  } seq_state_e;

  function automatic logic [ID_W-1:0] data_slot(input logic tet, input logic [POS_W-1:0] pos);
    if (tet) begin
      if (int'(pos) < CORNERS) return ID_W'(SLOT_CORNER0 + int'(pos));
      else if (int'(pos) == CORNERS) return ID_W'(SLOT_SRC);
      else return ID_W'(SLOT_DST);
    end else begin
      if (pos == '0) return ID_W'(SLOT_PACKED);
      else if (int'(pos) == 1) return ID_W'(SLOT_SRC);
      else return ID_W'(SLOT_DST);
    end
  endfunction
endpackage

// File: rtl/warp_tok_split.sv
module warp_tok_split
  import warp_cmd_pkg::*;
#(
  parameter int TW   = TOK_W,
  parameter int IW   = ID_W,
  parameter int VW   = DAT_VAL_W,
  parameter int CW   = CFG_VAL_W
) (
  input  logic [TW-1:0] tok,
  output logic          is_cfg,
  output logic          run_flag,
  output logic [IW-1:0] cfg_id,
  output logic [VW-1:0] cfg_val,
  output logic [VW-1:0] dat_val
);
  assign is_cfg   = tok[CMD_BIT];
  assign run_flag = tok[RUN_BIT];
  assign cfg_id   = tok[ID_LSB +: IW];
  assign cfg_val  = {{(VW-CW){1'b0}}, tok[CW-1:0]};
  assign dat_val  = tok[VW-1:0];
endmodule

// File: rtl/warp_seq_ctrl.sv
module warp_seq_ctrl
  import warp_cmd_pkg::*;
#(
  parameter int IW = ID_W,
  parameter int PW = POS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_fire,
  input  logic          tok_is_cfg,
  input  logic          cfg_mode,
  input  logic          job_done,
  output logic          busy,
  output logic          job_start,
  output logic [1:0]    state_code,
  output logic [PW-1:0] pos,
  output logic [IW-1:0] slot,
  output logic          seq_last,
  output logic          eff_tet
);
  localparam logic [PW-1:0] SCALE_END = PW'(SCALE_LEN - 1);
  localparam logic [PW-1:0] TETRA_END = PW'(TETRA_LEN - 1);

  seq_state_e    state_q;
  logic [PW-1:0] pos_q;
  logic          tet_q;
  logic          start_q;
  logic          data_fire;

  assign eff_tet    = (state_q == SEQ_IDLE) ? cfg_mode : tet_q;
  assign data_fire  = tok_fire && !tok_is_cfg;
  assign seq_last   = data_fire && (pos_q == (eff_tet ? TETRA_END : SCALE_END));
  assign slot       = data_slot(eff_tet, pos_q);
  assign busy       = (state_q == SEQ_BUSY);
  assign job_start  = start_q;
  assign state_code = state_q;
  assign pos        = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      pos_q   <= '0;
      tet_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= seq_last;
      case (state_q)
        SEQ_IDLE: if (data_fire) begin
          tet_q   <= cfg_mode;
          pos_q   <= PW'(1);
          state_q <= SEQ_COLLECT;
        end
        SEQ_COLLECT: if (data_fire) begin
          if (seq_last) begin
            pos_q   <= '0;
            state_q <= SEQ_BUSY;
          end else begin
            pos_q <= pos_q + PW'(1);
          end
        end
        SEQ_BUSY: if (job_done) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    job_start |=> !job_start); // R7
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    job_start |-> busy); // R7
  AST_BUSY_WAITS: assert property (@(posedge clk) disable iff (rst)
    (busy && !job_done) |=> busy); // R8
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && job_done) |=> !busy); // R8
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tok_fire); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_COLLECT && $past(state_q == SEQ_COLLECT)) |-> $stable(tet_q)); // R9
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_COLLECT) |-> (pos_q <= (tet_q ? TETRA_END : SCALE_END))); // R5
endmodule

// File: rtl/warp_reg_bank.sv
module warp_reg_bank
  import warp_cmd_pkg::*;
#(
  parameter int NS  = NUM_SLOTS,
  parameter int IW  = ID_W,
  parameter int VW  = DAT_VAL_W,
  parameter int RW  = TOK_W,
  parameter int FW  = 10,
  parameter int XW  = 6,
  parameter int NC  = CORNERS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [VW-1:0]  wr_val,
  input  logic [IW-1:0]  rd_idx,
  input  logic [RW-1:0]  status_word,
  output logic [RW-1:0]  rd_data,
  output logic           mode_bit,
  input  logic           snap_en,
  input  logic           snap_tet,
  input  logic           snap_run,
  input  logic [VW-1:0]  snap_dst,
  output logic           job_tetragon,
  output logic           job_run_flag,
  output logic [VW-1:0]  job_src,
  output logic [VW-1:0]  job_dst,
  output logic [FW-1:0]  job_frac_x,
  output logic [XW-1:0]  job_int_x,
  output logic [FW-1:0]  job_frac_y,
  output logic [NC*VW-1:0] job_corners,
  output logic [1:0]     job_interp,
  output logic           job_scan,
  output logic [1:0]     job_perf
);
  localparam int DEPTH = 1 << IW;
  localparam logic [IW-1:0] LIMIT = IW'(NS);

  logic [VW-1:0] slots_q [DEPTH];
  logic          wr_ok;

  assign wr_ok    = wr_en && (wr_idx != '0) && (wr_idx < LIMIT);
  assign mode_bit = slots_q[SLOT_MODE][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
    end else if (wr_ok) begin
      slots_q[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_idx == IW'(SLOT_STATUS)) begin
      rd_data <= status_word;
    end else if (rd_idx >= LIMIT) begin
      rd_data <= '0;
    end else begin
      rd_data <= {{(RW-VW){1'b0}}, slots_q[rd_idx]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      job_tetragon <= 1'b0;
      job_run_flag <= 1'b0;
      job_src      <= '0;
      job_dst      <= '0;
      job_frac_x   <= '0;
      job_int_x    <= '0;
      job_frac_y   <= '0;
      job_corners  <= '0;
      job_interp   <= '0;
      job_scan     <= 1'b0;
      job_perf     <= '0;
    end else if (snap_en) begin
      job_tetragon <= snap_tet;
      job_run_flag <= snap_run;
      job_src      <= slots_q[SLOT_SRC];
      job_dst      <= snap_dst;
      job_frac_x   <= slots_q[SLOT_PACKED][FW-1:0];
      job_int_x    <= slots_q[SLOT_PACKED][FW+XW-1:FW];
      job_frac_y   <= slots_q[SLOT_PACKED][2*FW+XW-1:FW+XW];
      for (int k = 0; k < NC; k++) job_corners[k*VW +: VW] <= slots_q[SLOT_CORNER0 + k];
      job_interp   <= slots_q[SLOT_INTERP][1:0];
      job_scan     <= slots_q[SLOT_SCAN][0];
      job_perf     <= slots_q[SLOT_PERF][1:0];
    end
  end

  AST_HIGH_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_idx) >= LIMIT) |-> (rd_data == '0)); // R3
  AST_SNAP_DST: assert property (@(posedge clk) disable iff (rst)
    snap_en |=> (job_dst == $past(snap_dst))); // R11
endmodule

// File: rtl/warp_cmd_decoder.sv
module warp_cmd_decoder
  import warp_cmd_pkg::*;
#(
  parameter int TW = TOK_W,
  parameter int IW = ID_W,
  parameter int VW = DAT_VAL_W,
  parameter int CW = CFG_VAL_W,
  parameter int NS = NUM_SLOTS,
  parameter int FW = 10,
  parameter int XW = 6,
  parameter int NC = CORNERS,
  parameter int PW = POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_valid,
  output logic             tok_ready,
  input  logic [TW-1:0]    tok_data,
  input  logic             job_done,
  input  logic [IW-1:0]    rd_idx,
  output logic [TW-1:0]    rd_data,
  output logic             busy,
  output logic             job_start,
  output logic             job_tetragon,
  output logic             job_run_flag,
  output logic [VW-1:0]    job_src,
  output logic [VW-1:0]    job_dst,
  output logic [FW-1:0]    job_frac_x,
  output logic [XW-1:0]    job_int_x,
  output logic [FW-1:0]    job_frac_y,
  output logic [NC*VW-1:0] job_corners,
  output logic [1:0]       job_interp,
  output logic             job_scan,
  output logic [1:0]       job_perf
);
  localparam int OPY_W = 14;

  logic          is_cfg, run_flag, tok_fire, mode_bit;
  logic          seq_last, eff_tet;
  logic [IW-1:0] cfg_id, slot, wr_idx;
  logic [VW-1:0] cfg_val, dat_val, wr_val;
  logic [1:0]    state_code;
  logic [PW-1:0] pos;
  logic [TW-1:0] status_word;

  assign tok_ready   = !busy;
  assign tok_fire    = tok_valid && tok_ready;
  assign wr_idx      = is_cfg ? cfg_id : slot;
  assign wr_val      = is_cfg ? cfg_val : dat_val;
  assign status_word = {{(TW-OPY_W-2){1'b0}}, {(OPY_W-PW){1'b0}}, pos, state_code};

  warp_tok_split #(.TW(TW), .IW(IW), .VW(VW), .CW(CW)) u_split (
    .tok(tok_data), .is_cfg(is_cfg), .run_flag(run_flag),
    .cfg_id(cfg_id), .cfg_val(cfg_val), .dat_val(dat_val)
  );

  warp_seq_ctrl #(.IW(IW), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .tok_fire(tok_fire), .tok_is_cfg(is_cfg),
    .cfg_mode(mode_bit), .job_done(job_done), .busy(busy),
    .job_start(job_start), .state_code(state_code), .pos(pos),
    .slot(slot), .seq_last(seq_last), .eff_tet(eff_tet)
  );

  warp_reg_bank #(.NS(NS), .IW(IW), .VW(VW), .RW(TW), .FW(FW), .XW(XW), .NC(NC)) u_bank (
    .clk(clk), .rst(rst), .wr_en(tok_fire), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_idx(rd_idx), .status_word(status_word), .rd_data(rd_data),
    .mode_bit(mode_bit), .snap_en(seq_last), .snap_tet(eff_tet),
    .snap_run(run_flag), .snap_dst(dat_val),
    .job_tetragon(job_tetragon), .job_run_flag(job_run_flag),
    .job_src(job_src), .job_dst(job_dst), .job_frac_x(job_frac_x),
    .job_int_x(job_int_x), .job_frac_y(job_frac_y), .job_corners(job_corners),
    .job_interp(job_interp), .job_scan(job_scan), .job_perf(job_perf)
  );
endmodule

// File: tb/warp_cmd_decoder_tb.sv
module warp_cmd_decoder_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tok_valid = 1'b0;
  logic         tok_ready;
  logic [31:0]  tok_data = '0;
  logic         job_done = 1'b0;
  logic [4:0]   rd_idx = '0;
  logic [31:0]  rd_data;
  logic         busy, job_start, job_tetragon, job_run_flag, job_scan;
  logic [25:0]  job_src, job_dst;
  logic [9:0]   job_frac_x, job_frac_y;
  logic [5:0]   job_int_x;
  logic [207:0] job_corners;
  logic [1:0]   job_interp, job_perf;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  warp_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_data(tok_data), .job_done(job_done), .rd_idx(rd_idx), .rd_data(rd_data),
    .busy(busy), .job_start(job_start), .job_tetragon(job_tetragon),
    .job_run_flag(job_run_flag), .job_src(job_src), .job_dst(job_dst),
    .job_frac_x(job_frac_x), .job_int_x(job_int_x), .job_frac_y(job_frac_y),
    .job_corners(job_corners), .job_interp(job_interp), .job_scan(job_scan),
    .job_perf(job_perf)
  );

  function automatic logic [31:0] ctok(input logic [4:0] id, input logic [24:0] v);
    return {1'b1, 1'b0, id, v};
  endfunction

  function automatic logic [31:0] dtok(input logic run, input logic [25:0] v);
    return {1'b0, run, 4'b0, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the taking edge
  task automatic send(input logic [31:0] t);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_data  = t;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] v);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic finish_job();
    repeat (3) @(negedge clk);
    check("R8 busy held", {31'b0, busy}, 32'd1);
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
    check("R8 busy cleared", {31'b0, busy}, 32'd0);
    check("R8 ready back", {31'b0, tok_ready}, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R12 ready", {31'b0, tok_ready}, 32'd1);
    check("R12 busy", {31'b0, busy}, 32'd0);
    check("R12 start", {31'b0, job_start}, 32'd0);
    check("R12 rd_data", rd_data, 32'd0);
    rd(5'd26, v);
    check("R4 mode default", v, 32'd0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    send(ctok(5'd1, 25'h1ABCDEF));
    rd(5'd1, v);
    check("R2 readback", v, 32'h01ABCDEF);
    send(ctok(5'd24, 25'd2));
    send(ctok(5'd25, 25'd1));
    send(ctok(5'd23, 25'd3));
    rd(5'd24, v);
    check("R2 slot 24", v, 32'd2);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    send(ctok(5'd28, 25'h1234));
    rd(5'd28, v);
    check("R3 slot 28 zero", v, 32'd0);
    send(ctok(5'd0, 25'h3FF));
    rd(5'd0, v);
    check("R3 R10 slot 0 idle", v, 32'd0);
  endtask

  task automatic t_scaling();
    logic [31:0] v;
    logic [25:0] packed_w;
    packed_w = {10'h2A5, 6'h2D, 10'h1C3};
    send(dtok(1'b0, packed_w));
    rd(5'd0, v);
    check("R10 collecting pos1", v, 32'h5);
    send(dtok(1'b0, 26'h0123456));
    check("R4 no early start", {31'b0, job_start}, 32'd0);
    send(dtok(1'b1, 26'h3000001));
    check("R7 start pulse", {31'b0, job_start}, 32'd1);
    check("R7 busy rises", {31'b0, busy}, 32'd1);
    check("R1 ready low", {31'b0, tok_ready}, 32'd0);
    check("R11 mode scaling", {31'b0, job_tetragon}, 32'd0);
    check("R11 src", {6'b0, job_src}, 32'h0123456);
    check("R11 dst", {6'b0, job_dst}, 32'h3000001);
    check("R11 run flag", {31'b0, job_run_flag}, 32'd1);
    check("R6 frac_x", {22'b0, job_frac_x}, 32'h1C3);
    check("R6 int_x", {26'b0, job_int_x}, 32'h2D);
    check("R6 frac_y", {22'b0, job_frac_y}, 32'h2A5);
    check("R11 interp", {30'b0, job_interp}, 32'd2);
    check("R11 scan", {31'b0, job_scan}, 32'd1);
    check("R11 perf", {30'b0, job_perf}, 32'd3);
    @(negedge clk);
    check("R7 pulse ends", {31'b0, job_start}, 32'd0);
    rd(5'd0, v);
    check("R10 busy state", v, 32'h2);
    rd(5'd4, v);
    check("R4 slot 4", v, {6'b0, packed_w});
    rd(5'd11, v);
    check("R4 slot 11", v, 32'h3000001);
    // offer a token while busy; it must not be taken
    @(negedge clk);
    tok_valid = 1'b1;
    tok_data  = ctok(5'd10, 25'h777);
    repeat (2) @(negedge clk);
    check("R1 ready low while offered", {31'b0, tok_ready}, 32'd0);
    tok_valid = 1'b0;
    finish_job();
    rd(5'd10, v);
    check("R1 busy token ignored", v, 32'd0);
  endtask

  task automatic t_tetragon();
    logic [31:0] v;
    send(ctok(5'd26, 25'd1));
    for (int k = 0; k < 3; k++) send(dtok(1'b0, 26'h0200000 + 26'(k * 'h111)));
    send(ctok(5'd26, 25'd0));
    send(ctok(5'd10, 25'h55));
    rd(5'd0, v);
    check("R9 count kept", v, 32'hD);
    for (int k = 3; k < 8; k++) send(dtok(1'b0, 26'h0200000 + 26'(k * 'h111)));
    send(dtok(1'b0, 26'h0ABCDE));
    check("R5 no start before last", {31'b0, job_start}, 32'd0);
    send(dtok(1'b0, 26'h1234567));
    check("R5 start after ten", {31'b0, job_start}, 32'd1);
    check("R9 mode deferred", {31'b0, job_tetragon}, 32'd1);
    check("R11 tetra src", {6'b0, job_src}, 32'h0ABCDE);
    check("R11 tetra dst", {6'b0, job_dst}, 32'h1234567);
    for (int k = 0; k < 8; k++)
      check("R11 corner", {6'b0, job_corners[k*26 +: 26]}, 32'h0200000 + 32'(k * 'h111));
    rd(5'd22, v);
    check("R5 slot 22", v, 32'h0200000 + 32'(7 * 'h111));
    rd(5'd10, v);
    check("R9 mid write stored", v, 32'h55);
    finish_job();
    // next sequence uses the scaling mode written mid-sequence
    send(dtok(1'b0, 26'h1));
    send(dtok(1'b0, 26'h2));
    send(dtok(1'b0, 26'h3));
    check("R9 new mode three tokens", {31'b0, job_start}, 32'd1);
    check("R9 new mode scaling", {31'b0, job_tetragon}, 32'd0);
    finish_job();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_ignored();
    t_scaling();
    t_tetragon();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule